// File: doc/BRIEF.md
# Phase Offset Recalibration Sequencer

This block re-aligns the phase offset between a timing loop's output clocks and its reference without making the output phase jump. Writing 1 to a self-clearing control bit starts a fixed sequence. The loop is first held in a short holdover. The internal offset is then walked to zero in bounded steps, and all output dividers are reset with a single strobe. After that the offset is walked back to the programmed value, holdover is released, and the control bit clears itself.

The block contains a stepped accumulator that stands in for the phase-offset ramp unit. Outside a recalibration this accumulator loads the programmed offset directly, so a plain write of the offset takes effect at once. During a recalibration every offset change is bounded by the step size. The loop filter, the phase detector and clock synthesis belong to the surrounding design.

Top module: `recal_sequencer`

## Requirements
- R1: A write (`cfg_wr`=1) with `cfg_wdata`=1 while `busy` is low raises `busy` one cycle later. A write with `cfg_wdata`=0 while idle leaves `busy` low and starts nothing.
- R2: `holdover` rises two cycles after the start write. It stays high through both ramps and the divider reset, and `ramp_req` is never high without `holdover`.
- R3: In the first ramp `ramp_target` is 0 and `ramp_req` is high. `phase_offset` moves toward 0 by `STEP` per cycle and lands exactly on 0 without overshoot.
- R4: `div_reset` is high for exactly one cycle, in the cycle after `phase_offset` reaches 0 in the first ramp, and only while `phase_offset` is 0.
- R5: After the divider reset, `ramp_target` equals `prog_offset` and `phase_offset` steps to it by at most `STEP` per cycle, ending exactly on it.
- R6: One cycle after the second ramp completes, `holdover` falls. `busy` falls one cycle after that.
- R7: Any write while `busy` is high, with data 0 or 1, has no effect. The sequence runs on unchanged and `busy` clears only at its normal end.
- R8: While `busy` is high, `phase_offset` changes by at most `STEP` per cycle. While idle, it equals the `prog_offset` of the previous cycle.
- R9: After reset `busy`, `holdover`, `ramp_req` and `div_reset` are low and `phase_offset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the recalibrate control bit |
| cfg_wdata | input | 1 | Value written to the control bit |
| prog_offset | input | W | Programmed phase offset, signed |
| busy | output | 1 | Control bit readback; high from start until the sequence ends |
| holdover | output | 1 | Holds the loop in short-term holdover |
| ramp_req | output | 1 | Ramp request to the offset ramp unit |
| ramp_target | output | W | Signed target of the current ramp |
| ramp_done | output | 1 | Ramp unit has reached its target |
| div_reset | output | 1 | One-cycle reset strobe for the output dividers |
| phase_offset | output | W | Current internal phase offset, signed |

## Verification
The sequence runs with a positive offset that is not a step multiple, a negative one, an exact step multiple, zero, and a large value. These cases separate the clamped final step from the regular steps and show the zero-length ramps that finish in their first cycle. The long ramps check that the timing holds over many steps. Starts and clears written in the middle of a run show whether writes are blocked while busy, and a zero written while idle shows whether it falsely starts a sequence. Offset changes made while idle separate direct loading from stepped movement.

// File: rtl/recal_pkg.sv
// Package: shared state encoding for the recalibration sequencer.
package recal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_ZERO   = 3'd2,
        ST_DIVRST = 3'd3,
        ST_BACK   = 3'd4,
        ST_EXIT   = 3'd5
    } recal_state_e;
endpackage

// File: rtl/recal_cfg_bit.sv
// Self-clearing recalibrate control bit.
// Assumes: writes are accepted only while the bit is clear; clr_i pulses
// once at the end of a sequence.
module recal_cfg_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic clr_i,
    output logic bit_o
);
    // Hold the bit: set by an idle write of 1, cleared by sequence end.
    always_ff @(posedge clk) begin
        if (!rst_n)                       bit_o <= 1'b0;
        else if (clr_i)                   bit_o <= 1'b0;
        else if (!bit_o && wr_i && wdata_i) bit_o <= 1'b1;
    end

    // R7: once set, only the end-of-sequence clear drops the bit
    a_r7_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_o && !clr_i) |=> bit_o);
    // R1: an idle write of 0 does not start anything
    a_r1_zero_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_o && wr_i && !wdata_i) |=> !bit_o);
endmodule

// File: rtl/recal_seq_fsm.sv
// Sequencer: hold -> ramp to zero -> divider reset -> ramp back -> release.
// Assumes: ramp_done_i is valid only while ramp_req_o is high.
module recal_seq_fsm
    import recal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ramp_done_i,
    output recal_state_e state_o,
    output logic holdover_o,
    output logic ramp_req_o,
    output logic use_zero_o,
    output logic div_reset_o,
    output logic seq_done_o
);
    recal_state_e nxt;

    // Next-state selection for the fixed sequence.
    always_comb begin
        nxt = state_o;
        unique case (state_o)
            ST_IDLE:   if (start_i) nxt = ST_HOLD;
            ST_HOLD:   nxt = ST_ZERO;
            ST_ZERO:   if (ramp_done_i) nxt = ST_DIVRST;
            ST_DIVRST: nxt = ST_BACK;
            ST_BACK:   if (ramp_done_i) nxt = ST_EXIT;
            ST_EXIT:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= nxt;
    end

    // Output decode from state.
    always_comb begin
        holdover_o  = (state_o == ST_HOLD) || (state_o == ST_ZERO) ||
                      (state_o == ST_DIVRST) || (state_o == ST_BACK);
        ramp_req_o  = (state_o == ST_ZERO) || (state_o == ST_BACK);
        use_zero_o  = (state_o == ST_ZERO);
        div_reset_o = (state_o == ST_DIVRST);
        seq_done_o  = (state_o == ST_EXIT);
    end

    // R4: divider reset strobe lasts a single cycle
    a_r4_div_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        div_reset_o |=> !div_reset_o);
    // R2: a ramp request never occurs outside holdover
    a_r2_req_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_req_o |-> holdover_o);
    // R6: holdover is released in the cycle before the sequence returns to idle
    a_r6_release_order: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |=> (!holdover_o && state_o == ST_IDLE));
endmodule

// File: rtl/recal_phase_ramp.sv
// Stepped phase-offset accumulator (model of the ramp unit).
// Loads the programmed value directly when load_i is high; otherwise, while
// req_i is high, moves toward target_i by STEP per cycle and clamps onto it.
module recal_phase_ramp #(
    parameter int W    = 16,
    parameter int STEP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic signed [W-1:0] load_val_i,
    input  logic                req_i,
    input  logic signed [W-1:0] target_i,
    output logic signed [W-1:0] acc_o,
    output logic                done_o
);
    localparam int DW = W + 1;
    localparam logic signed [DW-1:0] STEP_D = DW'(STEP);

    logic signed [DW-1:0] diff;
    logic signed [W-1:0]  acc_nxt;

    // Distance to target and the bounded next value.
    always_comb begin
        diff = DW'(target_i) - DW'(acc_o);
        if (diff > STEP_D)        acc_nxt = acc_o + W'(STEP);
        else if (diff < -STEP_D)  acc_nxt = acc_o - W'(STEP);
        else                      acc_nxt = target_i;
        done_o = req_i && (acc_o == target_i);
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_o <= '0;
        else if (load_i) acc_o <= load_val_i;
        else if (req_i)  acc_o <= acc_nxt;
    end

    // R8: while ramping, each move is bounded by the step
    a_r8_bounded_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !load_i) |=>
        ((DW'(acc_o) - DW'($past(acc_o))) <= STEP_D &&
         (DW'(acc_o) - DW'($past(acc_o))) >= -STEP_D));
    // R3: no overshoot, reaching the target sets done
    a_r3_hits_target: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !load_i && diff <= STEP_D && diff >= -STEP_D) |=>
        (acc_o == $past(target_i)));
endmodule

// File: rtl/recal_sequencer.sv
// Top: phase offset recalibration sequencer with its ramp unit model.
// Assumes: prog_offset is stable during the second ramp for an exact landing.
module recal_sequencer #(
    parameter int W    = 16,
    parameter int STEP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_wdata,
    input  logic signed [W-1:0] prog_offset,
    output logic                busy,
    output logic                holdover,
    output logic                ramp_req,
    output logic signed [W-1:0] ramp_target,
    output logic                ramp_done,
    output logic                div_reset,
    output logic signed [W-1:0] phase_offset
);
    import recal_pkg::*;

    recal_state_e state;
    logic use_zero, seq_done, load;

    recal_cfg_bit u_bit (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .wdata_i(cfg_wdata),
        .clr_i(seq_done), .bit_o(busy)
    );

    recal_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(busy), .ramp_done_i(ramp_done),
        .state_o(state), .holdover_o(holdover), .ramp_req_o(ramp_req),
        .use_zero_o(use_zero), .div_reset_o(div_reset), .seq_done_o(seq_done)
    );

    // Ramp target select and direct-load enable.
    always_comb begin
        ramp_target = use_zero ? '0 : prog_offset;
        load        = (state == ST_IDLE);
    end

    recal_phase_ramp #(.W(W), .STEP(STEP)) u_ramp (
        .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(prog_offset),
        .req_i(ramp_req), .target_i(ramp_target),
        .acc_o(phase_offset), .done_o(ramp_done)
    );

    // R4: dividers are reset only with the offset at zero
    a_r4_zero_at_divrst: assert property (@(posedge clk) disable iff (!rst_n)
        div_reset |-> (phase_offset == '0));
    // R6: busy stays up in the cycle holdover falls at sequence end
    a_r6_busy_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(holdover)) |-> busy);
endmodule

// File: tb/recal_sequencer_test.sv
module recal_sequencer_test;
    localparam int W = 16;
    localparam int STEP = 4;

    logic clk = 0, rst_n = 0, cfg_wr = 0, cfg_wdata = 0;
    logic signed [W-1:0] prog_offset = '0;
    logic busy, holdover, ramp_req, ramp_done, div_reset;
    logic signed [W-1:0] ramp_target, phase_offset;

    int checks = 0, fails = 0, cycles = 0;
    bit ended = 0;

    recal_sequencer #(.W(W), .STEP(STEP)) uut (.*);

    always #2 clk = ~clk;   // 250 MHz

    // Behavioural reference: stage 0 idle,1 hold,2 down,3 strobe,4 up,5 release
    int m_stage = 0, m_bit = 0, m_acc = 0;

    always @(posedge clk) begin
        int tgt, d, na, ns, nb;
        bit fin;
        if (!rst_n) begin
            m_stage <= 0; m_bit <= 0; m_acc <= 0;
        end else begin
            tgt = (m_stage == 2) ? 0 : int'(prog_offset);
            fin = (m_stage == 2 || m_stage == 4) && (m_acc == tgt);
            na = m_acc;
            if (m_stage == 0) na = int'(prog_offset);
            else if (m_stage == 2 || m_stage == 4) begin
                d = tgt - m_acc;
                if (d > STEP) na = m_acc + STEP;
                else if (d < -STEP) na = m_acc - STEP;
                else na = tgt;
            end
            nb = m_bit;
            if (m_stage == 5) nb = 0;
            else if (m_bit == 0 && cfg_wr && cfg_wdata) nb = 1;
            case (m_stage)
                0: ns = m_bit ? 1 : 0;
                1: ns = 2;
                2: ns = fin ? 3 : 2;
                3: ns = 4;
                4: ns = fin ? 5 : 4;
                default: ns = 0;
            endcase
            m_acc <= na; m_bit <= nb; m_stage <= ns;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) if (rst_n) begin
        check("R1/R6/R7", "busy", int'(busy), m_bit);
        check("R2", "holdover", int'(holdover), int'(m_stage >= 1 && m_stage <= 4));
        check("R3/R5", "ramp_req", int'(ramp_req), int'(m_stage == 2 || m_stage == 4));
        if (m_stage == 2) check("R3", "ramp_target", int'(ramp_target), 0);
        if (m_stage == 4) check("R5", "ramp_target", int'(ramp_target), int'(prog_offset));
        check("R4", "div_reset", int'(div_reset), int'(m_stage == 3));
        check("R8", "phase_offset", int'(phase_offset), m_acc);
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic v);
        cfg_wr = 1; cfg_wdata = v;
        tick(1);
        cfg_wr = 0; cfg_wdata = 0;
    endtask

    // Run one recalibration and wait for busy to fall.
    task automatic run_seq(input int off, input bit disturb);
        int guard = 0;
        prog_offset = W'(off);
        tick(2);
        check("R8", "idle load", int'(phase_offset), off);
        wr(1'b1);
        check("R1", "busy after start", int'(busy), 1);
        if (disturb) begin
            tick(3); wr(1'b0);   // R7: clear attempt ignored
            wr(1'b1);            // R7: restart attempt ignored
            check("R7", "busy after mid writes", int'(busy), 1);
        end
        while (busy && guard < 5000) begin tick(1); guard++; end
        check("R5", "final offset", int'(phase_offset), off);
        check("R6", "holdover after end", int'(holdover), 0);
    endtask

    initial begin
        tick(2);
        check("R9", "reset busy", int'(busy), 0);
        check("R9", "reset holdover", int'(holdover), 0);
        check("R9", "reset ramp_req", int'(ramp_req), 0);
        check("R9", "reset div_reset", int'(div_reset), 0);
        check("R9", "reset offset", int'(phase_offset), 0);
        rst_n = 1;
        tick(2);
        wr(1'b0);
        tick(1);
        check("R1", "zero write idle", int'(busy), 0);
        check("R1", "zero write idle hold", int'(holdover), 0);
        run_seq(10, 0);
        run_seq(-7, 1);
        run_seq(8, 0);
        run_seq(0, 0);
        run_seq(1000, 1);
        prog_offset = -16'sd300;
        tick(2);
        check("R8", "direct idle load", int'(phase_offset), -300);
        run_seq(-300, 0);
        tick(4);
        finish_run();
    end
endmodule